// File: doc/BRIEF.md
# Vector Component Unpack Sequencer

This block turns a stream of 32-bit input elements into writes of single components of a four-lane vector (lanes X, Y, Z, W, indices 0 to 3). A three-bit format code on each input beat chooses how elements map onto lanes: a scalar broadcast, two-, three- or four-element vectors, or a packed 16-bit colour word that expands into four lanes. Each clock the sequencer issues at most one component write, carrying a lane index and a 32-bit value, to a downstream lane filter.

For the two-, three- and four-element formats the sequencer keeps a saved lane offset. When an upstream chunk of elements ends partway through a vector, the offset is held, and the next chunk continues at the lane where the previous one stopped. Some formats fill their trailing lanes with the element at the head of the input without consuming it. The scalar and colour formats always build a whole vector from one element and have their own lane sweep, so they leave the saved offset alone.

Input uses a valid/ready handshake plus a count of elements left in the chunk. An element is taken when `inReady` is high. The element is present when `inValid` is high and `inCount` is not zero.

Top module: `vec_unpack_seq`

## Requirements
- R1: A synchronous active-high `rst` clears `outValid`, holds `inReady` low while asserted, and returns the saved offset and the lane sweep to lane X (index 0).
- R2: Format 0 (scalar) writes the head element to lanes 0, 1, 2, 3 on four successive writes and consumes it together with the lane-3 write.
- R3: Format 4 (colour) writes lane 0 = bits [4:0] shifted left by 3, lane 1 = bits [9:5] shifted left by 3, lane 2 = bits [14:10] shifted left by 3 and lane 3 = bit 15 shifted left by 7. Bits 31 to 16 have no effect. The element is consumed with the lane-3 write.
- R4: Format 1 (pair) consumes the head element on the writes at offsets 0 and 1. It writes lanes 2 and 3 with the head element without consuming it, then wraps the offset to 0.
- R5: Format 2 (triple) consumes the head element on the writes at offsets 0, 1 and 2. It writes lane 3 with the head element without consuming it, then wraps the offset to 0.
- R6: Format 3 (quad) consumes one element on every write. The offset advances by one on each write and wraps from lane 3 to lane 0.
- R7: The saved offset is held through cycles with no element present, so a vector split across chunks resumes at the saved lane.
- R8: Formats 0 and 4 always begin at lane 0 and leave the saved offset of formats 1 to 3 unchanged.
- R9: When `inValid` is low or `inCount` is zero, no write is issued, `inReady` stays low and no state changes.
- R10: Format codes 5, 6 and 7 consume the head element in one cycle and issue no write.
- R11: `inReady` is a same-cycle response to the presented element. The write decided in that cycle appears on `outValid`/`outIdx`/`outData` after exactly one clock edge, with at most one component per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| inValid | input | 1 | Head element present |
| inCount | input | COUNT_W | Elements left in the chunk, head included; zero means none |
| inFormat | input | 3 | Format code: 0 scalar, 1 pair, 2 triple, 3 quad, 4 colour, 5-7 reserved |
| inData | input | DATA_W | Head element |
| inReady | output | 1 | Head element consumed this cycle |
| outValid | output | 1 | Component write strobe |
| outIdx | output | 2 | Lane index of the write (0 = X ... 3 = W) |
| outData | output | DATA_W | Component value |

## Verification
If the saved offset is corrupted, the next pair, triple or quad write shows up one clock later with the wrong `outIdx`. The `inReady` pattern also goes wrong in that same cycle, because whether an element is consumed depends on the lane. An offset disturbed by a scalar or colour vector stays hidden until the next offset-based element arrives. The bench therefore puts those formats between the parts of a split vector. A faulty lane sweep gives the wrong colour field or releases the element early. Both are visible within four writes.

// File: rtl/vec_unpack_pkg.sv
package vec_unpack_pkg;
  localparam int LANES     = 4;
  localparam int LANE_W    = $clog2(LANES);
  localparam int LANE_LAST = LANES - 1;

  // packed colour word layout
  localparam int CHAN_W      = 5;
  localparam int CHAN_SHIFT  = 3;
  localparam int ALPHA_BIT   = 15;
  localparam int ALPHA_SHIFT = 7;

  typedef enum logic [2:0] {
    FMT_SCALAR = 3'd0,
    FMT_PAIR   = 3'd1,
    FMT_TRIPLE = 3'd2,
    FMT_QUAD   = 3'd3,
    FMT_COLOR  = 3'd4
  } fmt_e;

  typedef struct packed {
    logic              fire;
    logic [LANE_W-1:0] lane;
    logic              unpackColor;
  } strobe_t;
endpackage

// File: rtl/vec_unpack_ctrl.sv
module vec_unpack_ctrl
  import vec_unpack_pkg::*;
#(
  parameter int COUNT_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic [COUNT_W-1:0] inCount,
  input  logic [2:0]         inFormat,
  output logic               inReady,
  output strobe_t            strobe
);
  logic [LANE_W-1:0] offsetQ;
  logic [LANE_W-1:0] sweepQ;
  logic avail;
  logic consume;
  logic writes;
  logic useSweep;
  logic colorSel;

  always_comb begin
    avail    = inValid && (inCount != '0) && !rst;
    consume  = 1'b0;
    writes   = 1'b0;
    useSweep = 1'b0;
    colorSel = 1'b0;
    case (inFormat)
      FMT_SCALAR: begin
        writes   = 1'b1;
        useSweep = 1'b1;
        consume  = (sweepQ == LANE_W'(LANE_LAST));
      end
      FMT_COLOR: begin
        writes   = 1'b1;
        useSweep = 1'b1;
        colorSel = 1'b1;
        consume  = (sweepQ == LANE_W'(LANE_LAST));
      end
      FMT_PAIR: begin
        writes  = 1'b1;
        consume = (offsetQ < LANE_W'(2));
      end
      FMT_TRIPLE: begin
        writes  = 1'b1;
        consume = (offsetQ != LANE_W'(LANE_LAST));
      end
      FMT_QUAD: begin
        writes  = 1'b1;
        consume = 1'b1;
      end
      default: begin
        consume = 1'b1;
      end
    endcase
    inReady            = avail && consume;
    strobe.fire        = avail && writes;
    strobe.lane        = useSweep ? sweepQ : offsetQ;
    strobe.unpackColor = colorSel;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      offsetQ <= '0;
      sweepQ  <= '0;
    end else if (strobe.fire) begin
      if (useSweep) sweepQ <= sweepQ + LANE_W'(1);
      else          offsetQ <= offsetQ + LANE_W'(1);
    end
  end
endmodule

// File: rtl/vec_unpack_dp.sv
module vec_unpack_dp
  import vec_unpack_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DATA_W-1:0] inData,
  input  strobe_t           strobe,
  output logic              outValid,
  output logic [LANE_W-1:0] outIdx,
  output logic [DATA_W-1:0] outData
);
  logic [DATA_W-1:0] colorLane [LANES];
  logic [DATA_W-1:0] laneValue;

  for (genvar g = 0; g < LANES; g++) begin : g_color
    if (g < LANE_LAST) begin : g_chan
      assign colorLane[g] = DATA_W'(inData[g*CHAN_W +: CHAN_W]) << CHAN_SHIFT;
    end else begin : g_alpha
      assign colorLane[g] = DATA_W'(inData[ALPHA_BIT]) << ALPHA_SHIFT;
    end
  end

  always_comb begin
    laneValue = strobe.unpackColor ? colorLane[strobe.lane] : inData;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid <= 1'b0;
      outIdx   <= '0;
      outData  <= '0;
    end else begin
      outValid <= strobe.fire;
      if (strobe.fire) begin
        outIdx  <= strobe.lane;
        outData <= laneValue;
      end
    end
  end
endmodule

// File: rtl/vec_unpack_seq.sv
module vec_unpack_seq
  import vec_unpack_pkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int COUNT_W = 8
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic [COUNT_W-1:0] inCount,
  input  logic [2:0]         inFormat,
  input  logic [DATA_W-1:0]  inData,
  output logic               inReady,
  output logic               outValid,
  output logic [1:0]         outIdx,
  output logic [DATA_W-1:0]  outData
);
  strobe_t strobe;

  vec_unpack_ctrl #(.COUNT_W(COUNT_W)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .inValid  (inValid),
    .inCount  (inCount),
    .inFormat (inFormat),
    .inReady  (inReady),
    .strobe   (strobe)
  );

  vec_unpack_dp #(.DATA_W(DATA_W)) u_dp (
    .clk      (clk),
    .rst      (rst),
    .inData   (inData),
    .strobe   (strobe),
    .outValid (outValid),
    .outIdx   (outIdx),
    .outData  (outData)
  );
endmodule

// File: rtl/vec_unpack_seq_chk.sv
module vec_unpack_seq_chk #(
  parameter int COUNT_W = 8
) (
  input logic               clk,
  input logic               rst,
  input logic               inValid,
  input logic [COUNT_W-1:0] inCount,
  input logic [2:0]         inFormat,
  input logic               inReady,
  input logic               outValid,
  input logic [1:0]         outIdx
);
  logic present;
  assign present = inValid && (inCount != '0);

  a_r9_ready_needs_element: assert property (@(posedge clk) disable iff (rst)
    inReady |-> present);

  a_r9_idle_no_write: assert property (@(posedge clk) disable iff (rst)
    !present |=> !outValid);

  a_r6_quad_always_consumes: assert property (@(posedge clk) disable iff (rst)
    (present && inFormat == 3'd3) |-> inReady);

  a_r2_scalar_taken_on_w: assert property (@(posedge clk) disable iff (rst)
    (inReady && inFormat == 3'd0) |=> (outValid && outIdx == 2'd3));

  a_r3_color_taken_on_w: assert property (@(posedge clk) disable iff (rst)
    (inReady && inFormat == 3'd4) |=> (outValid && outIdx == 2'd3));

  a_r4_pair_hold_upper: assert property (@(posedge clk) disable iff (rst)
    (present && inFormat == 3'd1 && !inReady) |=> (outValid && outIdx[1]));

  a_r5_triple_hold_w: assert property (@(posedge clk) disable iff (rst)
    (present && inFormat == 3'd2 && !inReady) |=> (outValid && outIdx == 2'd3));

  a_r10_reserved_silent: assert property (@(posedge clk) disable iff (rst)
    (present && inFormat >= 3'd5) |=> (!outValid));
endmodule

bind vec_unpack_seq vec_unpack_seq_chk #(.COUNT_W(COUNT_W)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .inValid  (inValid),
  .inCount  (inCount),
  .inFormat (inFormat),
  .inReady  (inReady),
  .outValid (outValid),
  .outIdx   (outIdx)
);

// File: tb/sim_vec_unpack_seq.sv
module sim_vec_unpack_seq;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [7:0]  inCount = '0;
  logic [2:0]  inFormat = '0;
  logic [31:0] inData = '0;
  logic        inReady;
  logic        outValid;
  logic [1:0]  outIdx;
  logic [31:0] outData;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  logic [1:0] mOff = '0;
  logic [1:0] mSw = '0;

  always #2 clk = ~clk;

  vec_unpack_seq u0 (
    .clk(clk), .rst(rst), .inValid(inValid), .inCount(inCount),
    .inFormat(inFormat), .inData(inData), .inReady(inReady),
    .outValid(outValid), .outIdx(outIdx), .outData(outData)
  );

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] colorField(input logic [1:0] lane, input logic [31:0] d);
    case (lane)
      2'd0:    return {24'd0, d[4:0], 3'b000};
      2'd1:    return {24'd0, d[9:5], 3'b000};
      2'd2:    return {24'd0, d[14:10], 3'b000};
      default: return {24'd0, d[15], 7'd0};
    endcase
  endfunction

  function automatic bit takesHead(input logic [2:0] f, input logic [1:0] off, input logic [1:0] sw);
    case (f)
      3'd0, 3'd4: return sw == 2'd3;
      3'd1:       return off <= 2'd1;
      3'd2:       return off != 2'd3;
      3'd3:       return 1'b1;
      default:    return 1'b1;
    endcase
  endfunction

  function automatic string tagOf(input logic [2:0] f);
    case (f)
      3'd0: return "R2";
      3'd1: return "R4";
      3'd2: return "R5";
      3'd3: return "R6";
      3'd4: return "R3";
      default: return "R10";
    endcase
  endfunction

  task automatic step(input bit v, input logic [2:0] f, input logic [7:0] c, input logic [31:0] d, input string tag);
    bit avail, expReady, expFire;
    logic [1:0] expLane;
    logic [31:0] expVal;
    @(negedge clk);
    inValid = v; inFormat = f; inCount = c; inData = d;
    #1;
    avail    = v && (c != 0);
    expFire  = avail && (f <= 3'd4);
    expReady = avail && takesHead(f, mOff, mSw);
    expLane  = (f == 3'd0 || f == 3'd4) ? mSw : mOff;
    expVal   = (f == 3'd4) ? colorField(expLane, d) : d;
    chk(avail ? tag : "R9", "inReady", 32'(inReady), 32'(expReady));
    if (expFire) begin
      if (f == 3'd0 || f == 3'd4) mSw = mSw + 2'd1;
      else                        mOff = mOff + 2'd1;
    end
    @(posedge clk); #1;
    chk("R11", "outValid", 32'(outValid), 32'(expFire));
    if (expFire) begin
      chk(tag, "outIdx", 32'(outIdx), 32'(expLane));
      chk(tag, "outData", outData, expVal);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [2:0] f;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(posedge clk);
    #1;
    chk("R1", "outValid in reset", 32'(outValid), 32'd0);
    chk("R1", "inReady in reset", 32'(inReady), 32'd0);
    @(negedge clk); rst = 1'b0;

    // R1: first quad element after reset lands on lane X
    step(1, 3'd3, 8'd4, 32'h0000_00A0, "R1");
    // R6: finish the quad vector, wrap to X
    step(1, 3'd3, 8'd3, 32'h0000_00A1, "R6");
    step(1, 3'd3, 8'd2, 32'h0000_00A2, "R6");
    step(1, 3'd3, 8'd1, 32'h0000_00A3, "R6");
    // R7: split quad vector, gap, then resume
    step(1, 3'd3, 8'd2, 32'h1111_0001, "R7");
    step(1, 3'd3, 8'd1, 32'h1111_0002, "R7");
    step(0, 3'd3, 8'd5, 32'hDEAD_BEEF, "R9");
    step(1, 3'd3, 8'd0, 32'hDEAD_BEEF, "R9");
    // R8: scalar in the middle starts at X and leaves the offset
    for (int i = 0; i < 4; i++) step(1, 3'd0, 8'd1, 32'h5CA1_A400, "R8");
    // R3: colour word with noisy upper half
    for (int i = 0; i < 4; i++) step(1, 3'd4, 8'd1, 32'hFFFF_8421, "R3");
    step(1, 3'd3, 8'd2, 32'h1111_0003, "R7");
    chk("R8", "resumed lane", 32'(outIdx), 32'd2);
    step(1, 3'd3, 8'd1, 32'h1111_0004, "R7");
    // R10: reserved code
    step(1, 3'd6, 8'd1, 32'h0BAD_0BAD, "R10");
    // R4 / R5 directed vectors
    for (int i = 0; i < 4; i++) step(1, 3'd1, 8'd3, 32'h2000_0000 + 32'(i), "R4");
    for (int i = 0; i < 4; i++) step(1, 3'd2, 8'd3, 32'h3000_0000 + 32'(i), "R5");
    // R3: all-ones colour fields
    for (int i = 0; i < 4; i++) step(1, 3'd4, 8'd1, 32'h0000_FFFF, "R3");

    f = 3'd3;
    for (int n = 0; n < 4000; n++) begin
      bit v;
      logic [7:0] c;
      if ($urandom % 6 == 0) begin
        int r = $urandom % 10;
        f = (r < 8) ? 3'(r % 5) : 3'(5 + $urandom % 3);
      end
      v = ($urandom % 8) != 0;
      c = ($urandom % 6 == 0) ? 8'd0 : 8'(1 + $urandom % 8);
      step(v, f, c, $urandom, tagOf(f));
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule